// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives one asynchronous serial line and queues the characters it assembles. A 16× sampling enable arrives from an external rate generator. Each frame is one start bit, 5 to 8 data bits sent least significant bit first, an optional parity or address bit, and a stop bit. Every completed character is stored together with its own parity-error, framing-error, break and address flags. The storage is three holding slots plus a fourth place that stands for the receive shift register.

A consumer reads the head of the queue through a combinational view and removes it with a one-cycle pop strobe. Status outputs show that data is waiting, that the holding slots are full, and that a character was lost. A flow-control output can stop the remote sender while the holding slots are full. In multidrop mode the bit after the data carries an address/data mark, and a disabled receiver accepts only address characters. Line breaks are reported as a stored zero character and as separate start and end pulses.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the queue is empty: rx_ready, fifo_full and overrun are 0, rts_n is 0, and the receiver is disabled.
- R2: The line idles high and a start bit is low. Data bits arrive least significant bit first. cfg_len selects 0=5, 1=6, 2=7 or 3=8 data bits, and unused upper bits of rd_data read 0.
- R3: A start bit that is high again at its mid-bit sample is discarded, and no character is stored.
- R4: cfg_par selects 0=none, 1=even, 2=odd or 3=forced. In forced mode the received parity bit must equal cfg_par_force. rd_perr is 1 when the parity check fails.
- R5: rd_ferr is 1 when the stop bit is sampled low at its mid-bit point.
- R6: Characters are read in arrival order. rx_ready is 1 while at least one character is held, and fifo_full is 1 while all three holding slots are used.
- R7: A character that completes while the holding slots and the shift-register place are all occupied replaces the one in the shift-register place. The characters already queued are kept. overrun then sets and stays set until cmd_reset_err.
- R8: With cfg_auto_rts set, rts_n is 1 while the holding slots are full and 0 otherwise. With cfg_auto_rts clear, rts_n stays 0.
- R9: A frame in which every data bit, the parity bit and the stop bit are all low is stored once with data 0, rd_brk=1, rd_ferr=1 and rd_perr=0. brk_start pulses for one cycle. brk_end pulses for one cycle when the line returns high, and no character is stored in between.
- R10: A break that begins in the middle of a character closes that character with a framing error and is then reported as a break.
- R11: cmd_enable and cmd_disable switch the receiver. Outside multidrop mode, a disabled receiver stores nothing.
- R12: With cfg_multidrop set, the bit after the data is the address mark (1 = address, 0 = data) and is shown on rd_addr, and no parity check is made. A disabled receiver stores address characters only. An enabled receiver stores both kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Sampling enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, asynchronous |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par | input | 2 | Parity mode |
| cfg_par_force | input | 1 | Expected value of a forced parity bit |
| cfg_multidrop | input | 1 | Address/data mark replaces parity |
| cfg_auto_rts | input | 1 | Automatic flow control enable |
| cmd_enable | input | 1 | Strobe: enable receiver |
| cmd_disable | input | 1 | Strobe: disable receiver |
| cmd_reset_err | input | 1 | Strobe: clear overrun |
| rd_pop | input | 1 | Strobe: remove head character |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head character parity error |
| rd_ferr | output | 1 | Head character framing error |
| rd_brk | output | 1 | Head character is a break |
| rd_addr | output | 1 | Head character address mark |
| rx_ready | output | 1 | At least one character held |
| fifo_full | output | 1 | Holding slots full |
| overrun | output | 1 | Sticky character-loss flag |
| rts_n | output | 1 | Request-to-send, active low |
| brk_start | output | 1 | Pulse at break detection |
| brk_end | output | 1 | Pulse when the line leaves break |

## Verification
The assertions assume that configuration inputs change only while the receiver is hunting for a start bit and never while the queue is full with flow control on. They also assume that pop strobes are not issued back to back. The bench changes cfg_len, cfg_par and the mode bits only between frames, after the idle gap has ended. The monitor raises rd_pop for one cycle and then drops it for at least one cycle. Line stimulus is held for whole 16-tick bit times, and tick16 stays high, so every sample lands well inside a bit.

// File: rtl/serial_rx_queue.sv
`timescale 1ns/1ps
module serial_rx_queue #(
  parameter int HOLD = 3,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic [1:0]    cfg_par,
  input  logic          cfg_par_force,
  input  logic          cfg_multidrop,
  input  logic          cfg_auto_rts,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          cmd_reset_err,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          rd_addr,
  output logic          rx_ready,
  output logic          fifo_full,
  output logic          overrun,
  output logic          rts_n,
  output logic          brk_start,
  output logic          brk_end
);
  localparam int PW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int CW = $clog2(HOLD + 1);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;
  typedef struct packed {
    logic          addr;
    logic          brk;
    logic          ferr;
    logic          perr;
    logic [DW-1:0] data;
  } ent_t;

  logic rx_m, rx_s;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  st_t           st;
  logic [3:0]    tcnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic          pbit, allz, rx_en;

  wire [BW-1:0] last_idx  = BW'(DW - 4) + BW'(cfg_len);
  wire          has9      = cfg_multidrop | (cfg_par != 2'd0);
  wire          mid       = tick16 && (tcnt == 4'd15);
  wire          stop_samp = (st == S_STOP) && mid;
  wire          new_brk   = allz & ~rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      allz      <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
    end else begin
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      case (st)
        S_IDLE: if (tick16 && !rx_s) begin
          st   <= S_START;
          tcnt <= '0;
          sh   <= '0;
          pbit <= 1'b0;
          allz <= 1'b1;
        end
        S_START: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end
        end
        S_DATA: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            sh[bidx] <= rx_s;
            allz     <= allz & ~rx_s;
            bidx     <= bidx + 1'b1;
            if (bidx == last_idx) st <= has9 ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            pbit <= rx_s;
            allz <= allz & ~rx_s;
            st   <= S_STOP;
          end
        end
        S_STOP: if (tick16) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            if (new_brk) begin
              st        <= S_BRK;
              brk_start <= 1'b1;
            end else st <= S_IDLE;
          end
        end
        S_BRK: if (rx_s) begin
          st      <= S_IDLE;
          brk_end <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_en <= 1'b0;
    else if (cmd_enable) rx_en <= 1'b1;
    else if (cmd_disable) rx_en <= 1'b0;
  end

  logic perr_c;
  always_comb begin
    case (cfg_par)
      2'd1:    perr_c = ^sh ^ pbit;
      2'd2:    perr_c = ~(^sh ^ pbit);
      2'd3:    perr_c = pbit ^ cfg_par_force;
      default: perr_c = 1'b0;
    endcase
    if (cfg_multidrop || new_brk) perr_c = 1'b0;
  end

  ent_t new_ent;
  assign new_ent = '{addr: cfg_multidrop & pbit, brk: new_brk, ferr: ~rx_s,
                     perr: perr_c, data: sh};
  wire load_ok = rx_en | (cfg_multidrop & pbit);
  wire push    = stop_samp & load_ok;

  ent_t          mem [HOLD];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  ent_t          sr_q;
  logic          sr_v, rts_q;

  wire full = (cnt == CW'(HOLD));
  wire pop  = rd_pop && (cnt != '0);

  logic wr;
  ent_t wval;
  always_comb begin
    wr   = 1'b0;
    wval = new_ent;
    if (pop && sr_v) begin
      wr   = 1'b1;
      wval = sr_q;
    end else if (push && (!full || pop)) wr = 1'b1;
  end

  wire [CW-1:0] cnt_nxt = cnt + CW'(wr) - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HOLD; i++) mem[i] <= '0;
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      sr_q    <= '0;
      sr_v    <= 1'b0;
      overrun <= 1'b0;
      rts_q   <= 1'b0;
    end else begin
      if (wr) begin
        mem[wp] <= wval;
        wp      <= (wp == PW'(HOLD - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(HOLD - 1)) ? '0 : rp + 1'b1;
      cnt   <= cnt_nxt;
      rts_q <= cfg_auto_rts && (cnt_nxt == CW'(HOLD));
      if (cmd_reset_err) overrun <= 1'b0;
      if (pop && sr_v) begin
        sr_v <= push;
        if (push) sr_q <= new_ent;
      end else if (push && full && !pop) begin
        sr_q <= new_ent;
        sr_v <= 1'b1;
        if (sr_v) overrun <= 1'b1;
      end
    end
  end

  ent_t head;
  assign head      = mem[rp];
  assign rd_data   = head.data;
  assign rd_perr   = head.perr;
  assign rd_ferr   = head.ferr;
  assign rd_brk    = head.brk;
  assign rd_addr   = head.addr;
  assign rx_ready  = (cnt != '0);
  assign fifo_full = full;
  assign rts_n     = rts_q;

  a_r6_push_ready: assert property (@(posedge clk) disable iff (!rst_n)
    push && !rd_pop |=> rx_ready);
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !cmd_reset_err |=> overrun);
  a_r7_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_full));
  a_r8_rts_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && cfg_auto_rts && $stable(cfg_auto_rts) |-> rts_n);
  a_r9_brk_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> !brk_start);
  a_r9_no_store_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> !push);
  a_r11_disabled_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    push && !cfg_multidrop |-> rx_en);
endmodule

// File: tb/test_serial_rx_queue.sv
`timescale 1ns/1ps
module test_serial_rx_queue;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick16 = 1'b1, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
  logic cfg_par_force = 1'b0, cfg_multidrop = 1'b0, cfg_auto_rts = 1'b0;
  logic cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset_err = 1'b0;
  logic rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, rd_addr, rx_ready, fifo_full, overrun, rts_n;
  logic brk_start, brk_end;

  serial_rx_queue i_serial_rx_queue (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_force(cfg_par_force),
    .cfg_multidrop(cfg_multidrop), .cfg_auto_rts(cfg_auto_rts),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset_err(cmd_reset_err),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .rd_addr(rd_addr), .rx_ready(rx_ready), .fifo_full(fifo_full),
    .overrun(overrun), .rts_n(rts_n), .brk_start(brk_start), .brk_end(brk_end));

  int checks = 0, errors = 0, nbs = 0, nbe = 0;
  logic drain = 1'b0, done = 1'b0;
  logic [11:0] q[$];
  string qtag[$];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_ch(input logic [7:0] d, input logic pe, input logic fe,
                           input logic bk, input logic ad, input string tag);
    q.push_back({ad, bk, fe, pe, d});
    qtag.push_back(tag);
  endtask

  task automatic bits(input int n);
    repeat (16 * n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input logic has9,
                       input logic b9, input logic stopv);
    rxd = 1'b0; bits(1);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; bits(1); end
    if (has9) begin rxd = b9; bits(1); end
    rxd = stopv; bits(1);
    rxd = 1'b1; bits(2);
  endtask

  function automatic logic pbit_of(input logic [7:0] d, input int nb,
                                   input int mode, input logic f);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (mode == 1) return x;
    if (mode == 2) return ~x;
    return f;
  endfunction

  task automatic strobe(input int which);
    if (which == 0) cmd_enable = 1'b1;
    else if (which == 1) cmd_disable = 1'b1;
    else cmd_reset_err = 1'b1;
    @(negedge clk);
    cmd_enable = 1'b0; cmd_disable = 1'b0; cmd_reset_err = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (brk_start) nbs++;
      if (brk_end) nbe++;
      if (rd_pop) rd_pop = 1'b0;
      else if (drain && rx_ready) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected character actual %0h expected none", rd_data);
        end else begin
          logic [11:0] e, a;
          string t;
          e = q.pop_front();
          t = qtag.pop_front();
          a = {rd_addr, rd_brk, rd_ferr, rd_perr, rd_data};
          chk(a == e, t, int'(a), int'(e));
        end
        rd_pop = 1'b1;
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6: watchdog actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
    chk(fifo_full == 1'b0, "R1 fifo_full", fifo_full, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(rts_n == 1'b0, "R1 rts_n", rts_n, 0);

    frame(8'h55, 8, 1'b0, 1'b0, 1'b1);
    chk(rx_ready == 1'b0, "R11 disabled stores nothing", rx_ready, 0);
    chk(rx_ready == 1'b0, "R1 receiver disabled after reset", rx_ready, 0);

    strobe(0);
    drain = 1'b1;
    expect_ch(8'hA5, 0, 0, 0, 0, "R2 8 bit A5");
    frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
    expect_ch(8'h3C, 0, 0, 0, 0, "R2 8 bit 3C");
    frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);

    cfg_len = 2'd0; cfg_par = 2'd1;
    p = pbit_of(8'hEB, 5, 1, 1'b0);
    expect_ch(8'h0B, 0, 0, 0, 0, "R4 even ok / R2 5 bit");
    frame(8'hEB, 5, 1'b1, p, 1'b1);
    expect_ch(8'h0B, 1, 0, 0, 0, "R4 even bad");
    frame(8'hEB, 5, 1'b1, ~p, 1'b1);
    cfg_len = 2'd2; cfg_par = 2'd2;
    p = pbit_of(8'hDA, 7, 2, 1'b0);
    expect_ch(8'h5A, 0, 0, 0, 0, "R4 odd ok / R2 7 bit");
    frame(8'hDA, 7, 1'b1, p, 1'b1);
    expect_ch(8'h5A, 1, 0, 0, 0, "R4 odd bad");
    frame(8'hDA, 7, 1'b1, ~p, 1'b1);
    cfg_len = 2'd3; cfg_par = 2'd3; cfg_par_force = 1'b1;
    expect_ch(8'h81, 0, 0, 0, 0, "R4 forced ok");
    frame(8'h81, 8, 1'b1, 1'b1, 1'b1);
    expect_ch(8'h81, 1, 0, 0, 0, "R4 forced bad");
    frame(8'h81, 8, 1'b1, 1'b0, 1'b1);
    cfg_par = 2'd0;

    expect_ch(8'h3C, 0, 1, 0, 0, "R5 stop low");
    frame(8'h3C, 8, 1'b0, 1'b0, 1'b0);

    expect_ch(8'h00, 0, 1, 1, 0, "R9 break char");
    rxd = 1'b0; bits(12); rxd = 1'b1; bits(3);
    chk(nbs == 1, "R9 brk_start count", nbs, 1);
    chk(nbe == 1, "R9 brk_end count", nbe, 1);

    expect_ch(8'h07, 0, 1, 0, 0, "R10 cut character");
    expect_ch(8'h00, 0, 1, 1, 0, "R10 break after cut");
    rxd = 1'b0; bits(1); rxd = 1'b1; bits(3); rxd = 1'b0; bits(24); rxd = 1'b1; bits(3);
    chk(nbs == 2, "R10 brk_start count", nbs, 2);
    chk(nbe == 2, "R10 brk_end count", nbe, 2);

    cfg_auto_rts = 1'b1;
    drain = 1'b0;
    bits(1);
    chk(q.size() == 0, "R6 queue drained", q.size(), 0);
    expect_ch(8'h11, 0, 0, 0, 0, "R6 order 1");
    frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
    chk(rts_n == 1'b0, "R8 rts_n with space", rts_n, 0);
    chk(rx_ready == 1'b1, "R6 rx_ready one held", rx_ready, 1);
    expect_ch(8'h22, 0, 0, 0, 0, "R6 order 2");
    frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
    chk(fifo_full == 1'b0, "R6 two held not full", fifo_full, 0);
    expect_ch(8'h33, 0, 0, 0, 0, "R6 order 3");
    frame(8'h33, 8, 1'b0, 1'b0, 1'b1);
    chk(fifo_full == 1'b1, "R6 fifo_full", fifo_full, 1);
    chk(rts_n == 1'b1, "R8 rts_n deasserted when full", rts_n, 1);
    frame(8'h44, 8, 1'b0, 1'b0, 1'b1);
    chk(overrun == 1'b0, "R7 fourth held without overrun", overrun, 0);
    expect_ch(8'h55, 0, 0, 0, 0, "R7 newest replaces shift place");
    frame(8'h55, 8, 1'b0, 1'b0, 1'b1);
    chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
    drain = 1'b1;
    bits(2);
    chk(rx_ready == 1'b0, "R6 empty after drain", rx_ready, 0);
    chk(rts_n == 1'b0, "R8 rts_n reasserted", rts_n, 0);
    chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
    strobe(2);
    chk(overrun == 1'b0, "R7 overrun cleared", overrun, 0);
    cfg_auto_rts = 1'b0;

    cfg_multidrop = 1'b1;
    strobe(1);
    frame(8'h10, 8, 1'b1, 1'b0, 1'b1);
    chk(rx_ready == 1'b0, "R12 data ignored while disabled", rx_ready, 0);
    expect_ch(8'h42, 0, 0, 0, 1, "R12 address wakes");
    frame(8'h42, 8, 1'b1, 1'b1, 1'b1);
    frame(8'h13, 8, 1'b1, 1'b0, 1'b1);
    strobe(0);
    expect_ch(8'h14, 0, 0, 0, 0, "R12 data after enable");
    frame(8'h14, 8, 1'b1, 1'b0, 1'b1);
    cfg_multidrop = 1'b0;

    drain = 1'b0;
    rxd = 1'b0; repeat (5) @(negedge clk); rxd = 1'b1;
    bits(2);
    chk(rx_ready == 1'b0, "R3 false start discarded", rx_ready, 0);
    drain = 1'b1;
    expect_ch(8'h96, 0, 0, 0, 0, "R3 next frame intact");
    frame(8'h96, 8, 1'b0, 1'b0, 1'b1);

    bits(2);
    chk(q.size() == 0, "R6 all expected received", q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule